// File: doc/BRIEF.md
# Two-wire bus master controller

This block is a byte-oriented master for an open-drain two-wire serial bus with a clock line and a data line. A processor runs it through a small register port. Setting the master bit puts a start condition on the bus. Each write to the data register then moves one byte. The first byte after a start is always sent, because it carries the calling address. Later bytes are sent or received according to a direction bit. Clearing the master bit puts a stop condition on the bus. Both lines are driven as a pull-low enable, and each line is read back on its own input.

The block watches the bus lines at all times to keep a bus-busy flag. It reports a missing acknowledge after a byte it has sent. When receiving, it drives the acknowledge or holds it back, as a control bit selects. It reports lost arbitration in two cases: a request for master mode while the bus is busy, and a released data bit that reads back as zero. An interrupt output combines three flags, a module enable and the processor's global mask. Software clears each flag by writing 0 to it.

Top module: `twi_master`

## Requirements
- R1: After reset, every register bit reads 0, both line enables (`scl_oe`, `sda_oe`) are 0, and `irq` is 0.
- R2: A sent byte appears on the data line most significant bit first, one bit per clock pulse. A ninth clock pulse follows, during which the block releases the data line and samples the acknowledge.
- R3: One clock period on the bus lasts 4·BASE_DIV·2^speed system clocks, where speed is the field in bits 2..0 of the mode register (address 0).
- R4: The busy flag (bit 5 of address 0) sets when the data line falls while the clock line is high. It clears when the data line rises while the clock line is high. Both lines may be driven by this block or by another device.
- R5: The no-acknowledge flag (bit 6 of address 0) sets when the acknowledge bit reads 1 after a byte the block sent, whether that byte was an address or data. When a received byte's acknowledge is held back, the flag stays clear.
- R6: When receiving, the block pulls the data line low on the ninth clock if the ack-hold bit (bit 0 of address 1) is 0. It leaves the line high if that bit is 1. The received byte is read at address 2.
- R7: Writing 0 to a flag bit (address 0 bits 7 and 6, address 1 bit 7) clears it. Writing 1 leaves it unchanged.
- R8: `irq` is 1 exactly when at least one flag is set, the interrupt enable (bit 1 of address 1) is 1, and `cpu_imask` is 0.
- R9: The block may release the data line to send a 1 and then sample a 0. In that case the arbitration flag (bit 7 of address 0) sets, the master bit (bit 4 of address 0) clears, and both lines are released.
- R10: A write that sets the master bit while busy is 1 sets the arbitration flag instead. The master bit stays 0 and the lines stay released.
- R11: A start condition ends with both lines pulled low. During a byte, the data line changes only while the block holds the clock line low.
- R12: The byte-done flag (bit 7 of address 1) sets when each byte, including its ninth clock, is complete.
- R13: The first byte after a start is sent from the value written to address 2. Each later byte is received when the direction bit (bit 3 of address 0) is 1. Otherwise it is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode/status, 1 control, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| scl_in | input | 1 | Clock line level |
| sda_in | input | 1 | Data line level |
| scl_oe | output | 1 | Pull the clock line low when 1 |
| sda_oe | output | 1 | Pull the data line low when 1 |
| cpu_imask | input | 1 | Processor global interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with BASE_DIV set to 1, so one quarter of a bus clock period is exactly 2^speed system clocks. At speed 0 a full byte takes only 36 cycles, which keeps long runs of bytes cheap. Speed 2 is also used, so the bench can compare measured clock periods for two settings against the formula. A behavioural device on the bus can acknowledge, hold back the acknowledge, send a byte, or hold the data line low. Those four behaviours reach the acknowledge, receive and arbitration-loss paths.

// File: rtl/twi_master.sv
`timescale 1ns/1ps
module twi_master #(
  parameter int BASE_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       cpu_imask,
  output logic       irq
);
  localparam int QW = $clog2(BASE_DIV * 128) + 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_HOLD, S_XFER, S_STOP} st_t;
  st_t st;

  logic [QW-1:0] qcnt, qlen;
  logic [1:0] qtr;
  logic [3:0] bitc;
  logic [7:0] sh, rxd;
  logic [2:0] baud;
  logic alf, nakf, donef, busy, mast, mrw, ien, ack_off, first, rx, scl_q, sda_q;
  logic tick, start_ev, stop_ev, arb_hit, wr_mcr, wr_ctl, wr_dat, busy_req;

  assign qlen     = QW'(BASE_DIV) << baud;
  assign tick     = (st == S_START || st == S_XFER || st == S_STOP) && (qcnt == qlen - QW'(1));
  assign start_ev = scl_q && scl_in && sda_q && !sda_in;
  assign stop_ev  = scl_q && scl_in && !sda_q && sda_in;
  assign wr_mcr   = reg_wr && reg_addr == 2'd0;
  assign wr_ctl   = reg_wr && reg_addr == 2'd1;
  assign wr_dat   = reg_wr && reg_addr == 2'd2;
  assign busy_req = wr_mcr && reg_wdata[4] && !mast && busy;
  assign arb_hit  = st == S_XFER && tick && qtr == 2'd2 && !rx && !bitc[3] && !sda_oe && !sda_in;
  assign irq      = !cpu_imask && ien && (alf || nakf || donef);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {alf, nakf, busy, mast, mrw, baud};
      2'd1:    reg_rdata = {donef, 5'b0, ien, ack_off};
      2'd2:    reg_rdata = rxd;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      qcnt <= '0;
      qtr <= 2'd0;
      bitc <= 4'd0;
      sh <= 8'h00;
      rxd <= 8'h00;
      baud <= 3'd0;
      {alf, nakf, donef, busy, mast, mrw, ien, ack_off, first, rx} <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (start_ev) busy <= 1'b1;
      else if (stop_ev) busy <= 1'b0;
      qcnt <= (tick || st == S_IDLE || st == S_HOLD) ? '0 : qcnt + QW'(1);

      if (wr_mcr) begin
        alf  <= alf & reg_wdata[7];
        nakf <= nakf & reg_wdata[6];
        mrw  <= reg_wdata[3];
        baud <= reg_wdata[2:0];
        if (busy_req) alf <= 1'b1;
        else mast <= reg_wdata[4];
      end
      if (wr_ctl) begin
        donef   <= donef & reg_wdata[7];
        ien     <= reg_wdata[1];
        ack_off <= reg_wdata[0];
      end

      case (st)
        S_IDLE: if (mast) begin
          st <= S_START;
          qtr <= 2'd0;
        end
        S_START: if (tick) begin
          if (qtr == 2'd0) begin
            sda_oe <= 1'b1;
            qtr <= 2'd1;
          end else begin
            scl_oe <= 1'b1;
            first <= 1'b1;
            st <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (wr_dat) begin
            st <= S_XFER;
            qtr <= 2'd0;
            bitc <= 4'd0;
            sh <= reg_wdata;
            rx <= mrw && !first;
            first <= 1'b0;
          end else if (!mast) begin
            st <= S_STOP;
            qtr <= 2'd0;
          end
        end
        S_XFER: if (tick) begin
          qtr <= qtr + 2'd1;
          case (qtr)
            2'd0: sda_oe <= bitc[3] ? (rx && !ack_off) : (!rx && !sh[7]);
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              if (!bitc[3]) begin
                if (rx) sh <= {sh[6:0], sda_in};
              end else if (!rx && sda_in) begin
                nakf <= 1'b1;
              end
            end
            default: begin
              scl_oe <= 1'b1;
              if (bitc[3]) begin
                st <= S_HOLD;
                donef <= 1'b1;
                if (rx) rxd <= sh;
              end else begin
                bitc <= bitc + 4'd1;
                if (!rx) sh <= {sh[6:0], 1'b0};
              end
            end
          endcase
          if (arb_hit) begin
            st <= S_IDLE;
            mast <= 1'b0;
            alf <= 1'b1;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
          end
        end
        S_STOP: if (tick) begin
          qtr <= qtr + 2'd1;
          case (qtr)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            default: begin
              sda_oe <= 1'b0;
              st <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_busy_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_in && sda_q && !sda_in) |=> busy);

  assert_sda_quiet_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && $past(st) == S_XFER && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  assert_arb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_hit |=> (alf && !mast && !scl_oe && !sda_oe));

  assert_busy_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mcr && reg_wdata[4] && !mast && busy) |=> (alf && !mast));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && !cpu_imask));

  assert_no_nak_on_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && rx && !nakf) |=> !nakf);
endmodule

// File: tb/tb_twi_master.sv
`timescale 1ns/1ps
module tb_twi_master;
  localparam int BD = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic cpu_imask = 1'b0;
  logic ext_sda = 1'b0;
  logic ext_scl = 1'b0;
  int smode = 0;
  logic [7:0] sbyte = 8'h00;
  int sidx = 0;
  logic slv_pull;
  logic scl_line, sda_line;

  int checks = 0;
  int fails = 0;
  logic [8:0] expq[$];

  always #10 clk = ~clk;

  always_comb begin
    case (smode)
      1: slv_pull = (sidx == 8);
      2: slv_pull = (sidx >= 0 && sidx < 8) ? !sbyte[3'(7 - sidx)] : 1'b0;
      3: slv_pull = (sidx >= 0 && sidx < 8);
      default: slv_pull = 1'b0;
    endcase
  end

  assign scl_line = !(scl_oe || ext_scl);
  assign sda_line = !(sda_oe || ext_sda || slv_pull);

  twi_master #(.BASE_DIV(BD)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_line),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .cpu_imask(cpu_imask), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic pscl = 1'b1;
  logic psda = 1'b1;
  int mcnt = 0;
  logic [8:0] mbits = '0;
  int cyc = 0;
  int last_rise = 0;
  int prev_rise = 0;

  always @(negedge clk) begin
    cyc++;
    if (pscl && scl_line && psda && !sda_line) begin
      sidx = -1;
      mcnt = 0;
    end else if (pscl && !scl_line) begin
      sidx = (sidx == 8) ? 0 : sidx + 1;
    end
    if (!pscl && scl_line) begin
      prev_rise = last_rise;
      last_rise = cyc;
      mbits = {mbits[7:0], sda_line};
      mcnt++;
      if (mcnt == 9) begin
        mcnt = 0;
        if (expq.size() == 0) check("R2 R6 unexpected frame", int'(mbits), -1);
        else check("R2 R6 bus frame", int'(mbits), int'(expq.pop_front()));
      end
    end
    pscl = scl_line;
    psda = sda_line;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [7:0] d, input logic [8:0] expect_frame);
    logic [7:0] v;
    expq.push_back(expect_frame);
    wr(2'd2, d);
    for (int i = 0; i < 5000; i++) begin
      rd(2'd1, v);
      if (v[7]) break;
    end
    check("R12 byte done flag", int'(v[7]), 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(64'd20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    rd(2'd0, v); check("R1 mode register reset", int'(v), 0);
    rd(2'd1, v); check("R1 control register reset", int'(v), 0);
    check("R1 irq reset", int'(irq), 0);
    check("R1 scl_oe reset", int'(scl_oe), 0);
    check("R1 sda_oe reset", int'(sda_oe), 0);

    ext_sda = 1'b1; idle(3);
    rd(2'd0, v); check("R4 external start sets busy", int'(v[5]), 1);
    ext_sda = 1'b0; idle(3);
    rd(2'd0, v); check("R4 external stop clears busy", int'(v[5]), 0);

    wr(2'd0, 8'h10); idle(12);
    rd(2'd0, v); check("R4 own start sets busy", int'(v), 8'h30);
    check("R11 start leaves clock low", int'(scl_oe), 1);
    check("R11 start leaves data low", int'(sda_oe), 1);
    smode = 1;
    send(8'hA4, {8'hA4, 1'b0});
    rd(2'd0, v); check("R5 acknowledged byte leaves nak clear", int'(v[6]), 0);
    check("R3 period at speed 0", last_rise - prev_rise, 4 * BD);
    wr(2'd1, 8'h02);
    rd(2'd1, v); check("R7 done flag cleared by 0", int'(v), 8'h02);
    check("R8 no flag no irq", int'(irq), 0);

    smode = 0;
    send(8'h3C, {8'h3C, 1'b1});
    rd(2'd0, v); check("R5 missing ack sets nak", int'(v[6]), 1);
    check("R8 irq with enable", int'(irq), 1);
    cpu_imask = 1'b1; idle(1);
    check("R8 global mask blocks irq", int'(irq), 0);
    cpu_imask = 1'b0;
    wr(2'd0, 8'hD0);
    rd(2'd0, v); check("R7 writing 1 keeps flag", int'(v), 8'h70);
    wr(2'd0, 8'h10);
    rd(2'd0, v); check("R7 nak cleared by 0", int'(v), 8'h30);
    wr(2'd1, 8'h02); idle(1);
    check("R8 irq drops after clears", int'(irq), 0);
    wr(2'd0, 8'h00); idle(20);
    rd(2'd0, v); check("R4 own stop clears busy", int'(v), 0);
    check("R11 lines released after stop", int'({scl_oe, sda_oe}), 0);

    wr(2'd0, 8'h1A); idle(20);
    smode = 1;
    send(8'hA5, {8'hA5, 1'b0});
    check("R3 period at speed 2", last_rise - prev_rise, 16 * BD);
    wr(2'd1, 8'h02);
    smode = 2; sbyte = 8'h5A;
    send(8'h00, {8'h5A, 1'b0});
    rd(2'd2, v); check("R13 R6 received byte with ack", int'(v), 8'h5A);
    wr(2'd1, 8'h03);
    sbyte = 8'hC3;
    send(8'h00, {8'hC3, 1'b1});
    rd(2'd2, v); check("R6 received byte without ack", int'(v), 8'hC3);
    rd(2'd0, v); check("R5 held-back ack leaves nak clear", int'(v[6]), 0);
    smode = 0;
    wr(2'd0, 8'h00); idle(40);
    rd(2'd0, v); check("R4 stop after receive", int'(v), 0);

    wr(2'd1, 8'h02);
    wr(2'd0, 8'h10); idle(12);
    smode = 3;
    wr(2'd2, 8'h80); idle(20);
    rd(2'd0, v); check("R9 arbitration flag and master cleared", int'(v), 8'hA0);
    check("R9 lines released", int'({scl_oe, sda_oe}), 0);
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R7 arbitration flag cleared", int'(v), 8'h20);
    wr(2'd0, 8'h10); idle(10);
    rd(2'd0, v); check("R10 master request while busy", int'(v), 8'hA0);
    check("R10 lines stay released", int'({scl_oe, sda_oe}), 0);
    smode = 0; idle(4);
    rd(2'd0, v); check("R4 stop from other device", int'(v), 8'h80);
    check("R2 R6 all frames seen", expq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule